// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Address-Space Tags

This block caches page mappings for a processor front end. Every slot holds a virtual page number, a per-slot page-size mask, an address-space tag, a global flag, two valid flags (for an even and odd frame) and two physical frame numbers. All slots are compared in parallel against an incoming virtual address. A translation request comes in one of two kinds. A lookup returns hit, slot index and the frames of the winning slot. A probe returns only the slot index. Both results are registered and appear one cycle after the request.

Software fills the table by writing a complete slot at an explicit index. A flush empties every slot at once. A replacement pointer names the slot that software should fill next. Reading through that pointer returns the slot's contents and can step the pointer forward, wrapping at the end of the table. Two request-side checks run with every translation. Misaligned instruction fetches are refused. Addresses in a fixed high region are flagged as uncacheable. Page-table walking and fault handling belong to the surrounding logic.

Top module: `tlb_assoc`

## Requirements
- R1: A slot's stored page number matches the request page number (address bits 31..12) when the two agree in every bit that is clear in that slot's mask; bits set in the mask are not compared.
- R2: A page-number match counts as a hit only when the slot's global flag is set or the request tag equals the slot's tag.
- R3: A slot takes part in matching when at least one of its two valid flags is set; a slot with both flags clear never hits.
- R4: When several slots hit, the lowest-numbered slot is reported.
- R5: A request accepted in cycle t produces `res_valid` high in cycle t+1, along with the hit flag, the index, and the even/odd valid flags and frames of the winning slot. The index is 4 bits, and all ones (-1) means a miss. On a miss the valid flags and frames are zero.
- R6: A probe (`req_kind` = 1) reports the hit flag and index exactly as a lookup (`req_kind` = 0) would, with frames and valid flags forced to zero.
- R7: A write at an in-range index replaces every field of that slot; the slot's former page number stops hitting from the next request on.
- R8: A write whose index is at or above the slot count leaves the table unchanged and raises `wr_warn` for one cycle in the next cycle; in-range writes leave `wr_warn` low.
- R9: A flush clears every field of every slot, including both valid flags, and returns the replacement pointer to 0.
- R10: A pointer read returns, in the next cycle, the index and contents of the slot at the pointer (`nx_done` high). With `nx_adv` set, the pointer then steps by one, and from the last slot it steps back to 0. Without `nx_adv`, the pointer does not move.
- R11: A lookup with `req_fetch` set and either of address bits 1..0 set reports `res_align_fault` with a miss (index -1) whatever the table holds; probes never report this fault.
- R12: `res_uncached` is set when the request address ANDed with 0xA0000000 equals 0xA0000000, on hits and misses alike.
- R13: A write or flush in the same cycle as a request drops the request (`res_valid` stays low next cycle). A flush also wins over a write and a pointer read issued with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_kind | input | 1 | 0 lookup, 1 probe |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_va | input | 32 | Request virtual address |
| req_asid | input | 8 | Request address-space tag |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Some slot hit |
| res_idx | output | 4 | Winning slot, all ones on miss |
| res_v0 | output | 1 | Even valid flag of winner (lookup) |
| res_v1 | output | 1 | Odd valid flag of winner (lookup) |
| res_pfn0 | output | 20 | Even frame of winner (lookup) |
| res_pfn1 | output | 20 | Odd frame of winner (lookup) |
| res_align_fault | output | 1 | Misaligned fetch refused |
| res_uncached | output | 1 | Address in uncacheable region |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 4 | Slot to write |
| wr_vpn | input | 20 | Page number to store |
| wr_mask | input | 20 | Page-size mask to store |
| wr_asid | input | 8 | Tag to store |
| wr_global | input | 1 | Global flag to store |
| wr_v0 | input | 1 | Even valid flag to store |
| wr_v1 | input | 1 | Odd valid flag to store |
| wr_pfn0 | input | 20 | Even frame to store |
| wr_pfn1 | input | 20 | Odd frame to store |
| wr_warn | output | 1 | Out-of-range write seen |
| flush | input | 1 | Clear whole table |
| nx_rd | input | 1 | Read slot at replacement pointer |
| nx_adv | input | 1 | Step pointer after the read |
| nx_done | output | 1 | Pointer read result present |
| nx_idx | output | 3 | Pointer value that was read |
| nx_vpn | output | 20 | Page number of that slot |
| nx_mask | output | 20 | Mask of that slot |
| nx_asid | output | 8 | Tag of that slot |
| nx_global | output | 1 | Global flag of that slot |
| nx_v0 | output | 1 | Even valid flag of that slot |
| nx_v1 | output | 1 | Odd valid flag of that slot |
| nx_pfn0 | output | 20 | Even frame of that slot |
| nx_pfn1 | output | 20 | Odd frame of that slot |

## Verification
The table is loaded with five slots, and a vector set then sends requests against them. The set covers exact page hits and hits that rely only on the mask, so a compare that ignores the mask stands apart from one that applies it. A pair of requests differs only in the tag and another pair relies on the global flag, which exposes a tag compare that is missing or always enforced. Two slots that overlap and a slot with both valid flags clear show whether priority and validity are honoured. Fetch requests at each low-bit alignment, run as lookups and as probes, separate a correct fault gate from one that fires on the wrong request kind. The vector addresses sit inside, astride and outside the uncacheable pattern. Directed steps then evict, overflow the index, flush, collide writes with requests, and walk the pointer through its wrap.

// File: rtl/tlb_pkg.sv
// Package: shared request-kind encoding for the translation buffer.
// Assumes: one request kind bit on the top-level port.
package tlb_pkg;
    typedef enum logic {
        KIND_LOOKUP = 1'b0,
        KIND_PROBE  = 1'b1
    } req_kind_e;
endpackage

// File: rtl/tlb_slot_cmp.sv
// Module: tlb_slot_cmp
// Compares one stored slot against a request page number and tag.
// Assumes: mask bits set mean "do not compare"; either valid flag makes the
// slot live. Purely combinational.
module tlb_slot_cmp #(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic [VPN_W-1:0]  s_vpn,
    input  logic [VPN_W-1:0]  s_mask,
    input  logic [ASID_W-1:0] s_asid,
    input  logic              s_global,
    input  logic              s_v0,
    input  logic              s_v1,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [ASID_W-1:0] q_asid,
    output logic              hit
);
    logic page_eq;
    logic tag_ok;
    logic live;

    // Page agreement outside the masked bits.
    assign page_eq = ((q_vpn ^ s_vpn) & ~s_mask) == '0;
    // Global slots skip the tag compare.
    assign tag_ok  = s_global || (q_asid == s_asid);
    // Slot is live when either half is valid.
    assign live    = s_v0 | s_v1;
    // Final hit.
    assign hit     = page_eq && tag_ok && live;
endmodule

// File: rtl/tlb_first_hit.sv
// Module: tlb_first_hit
// Lowest-index priority encoder over the per-slot hit vector.
// Assumes: N >= 2. Combinational.
module tlb_first_hit #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Any slot hit.
    assign any = |hits;

    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_table.sv
// Module: tlb_table
// Slot storage with indexed write, whole-table flush and the replacement
// pointer. Assumes: flush has priority over write and over pointer step;
// reset is synchronous active-low; out-of-range writes are dropped here
// and flagged one cycle later.
module tlb_table #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int WIDX_W  = IDX_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           wr_en,
    input  logic [WIDX_W-1:0]              wr_idx,
    input  logic [VPN_W-1:0]               wr_vpn,
    input  logic [VPN_W-1:0]               wr_mask,
    input  logic [ASID_W-1:0]              wr_asid,
    input  logic                           wr_global,
    input  logic                           wr_v0,
    input  logic                           wr_v1,
    input  logic [PFN_W-1:0]               wr_pfn0,
    input  logic [PFN_W-1:0]               wr_pfn1,
    output logic                           wr_warn,
    input  logic                           ptr_step,
    output logic [IDX_W-1:0]               ptr,
    output logic [ENTRIES-1:0][VPN_W-1:0]  t_vpn,
    output logic [ENTRIES-1:0][VPN_W-1:0]  t_mask,
    output logic [ENTRIES-1:0][ASID_W-1:0] t_asid,
    output logic [ENTRIES-1:0]             t_global,
    output logic [ENTRIES-1:0]             t_v0,
    output logic [ENTRIES-1:0]             t_v1,
    output logic [ENTRIES-1:0][PFN_W-1:0]  t_pfn0,
    output logic [ENTRIES-1:0][PFN_W-1:0]  t_pfn1
);
    localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(ENTRIES);
    localparam logic [IDX_W-1:0]  LAST  = IDX_W'(ENTRIES - 1);

    logic             in_range;
    logic [IDX_W-1:0] slot;

    // Index legality and the slot number it selects.
    assign in_range = wr_idx < LIMIT;
    assign slot     = wr_idx[IDX_W-1:0];

    // Slot contents: reset or flush clears everything, else apply a legal write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            t_vpn    <= '0;
            t_mask   <= '0;
            t_asid   <= '0;
            t_global <= '0;
            t_v0     <= '0;
            t_v1     <= '0;
            t_pfn0   <= '0;
            t_pfn1   <= '0;
        end else if (wr_en && in_range) begin
            t_vpn[slot]    <= wr_vpn;
            t_mask[slot]   <= wr_mask;
            t_asid[slot]   <= wr_asid;
            t_global[slot] <= wr_global;
            t_v0[slot]     <= wr_v0;
            t_v1[slot]     <= wr_v1;
            t_pfn0[slot]   <= wr_pfn0;
            t_pfn1[slot]   <= wr_pfn1;
        end
    end

    // One-cycle flag for a write aimed past the table.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_warn <= 1'b0;
        else        wr_warn <= wr_en && !in_range;
    end

    // Replacement pointer: cleared by flush, wraps after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  ptr <= '0;
        else if (ptr_step)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/tlb_assoc.sv
// Module: tlb_assoc (top)
// Fully associative translation buffer: parallel masked compare, lowest-index
// priority, registered lookup/probe result, request-side alignment and
// uncacheable checks, and a registered read through the replacement pointer.
// Assumes: writes and flushes cancel a request in the same cycle; a flush
// also cancels a pointer read; VA_W > VPN_W and ENTRIES >= 2.
module tlb_assoc #(
    parameter int          ENTRIES   = 8,
    parameter int          VA_W      = 32,
    parameter int          VPN_W     = 20,
    parameter int          PFN_W     = 20,
    parameter int          ASID_W    = 8,
    parameter logic [31:0] UNC_MATCH = 32'hA000_0000,
    parameter int          IDX_W     = $clog2(ENTRIES),
    parameter int          WIDX_W    = IDX_W + 1,
    parameter int          RES_W     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_kind,
    input  logic              req_fetch,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    output logic              res_valid,
    output logic              res_hit,
    output logic [RES_W-1:0]  res_idx,
    output logic              res_v0,
    output logic              res_v1,
    output logic [PFN_W-1:0]  res_pfn0,
    output logic [PFN_W-1:0]  res_pfn1,
    output logic              res_align_fault,
    output logic              res_uncached,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [VPN_W-1:0]  wr_mask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic              wr_v0,
    input  logic              wr_v1,
    input  logic [PFN_W-1:0]  wr_pfn0,
    input  logic [PFN_W-1:0]  wr_pfn1,
    output logic              wr_warn,
    input  logic              flush,
    input  logic              nx_rd,
    input  logic              nx_adv,
    output logic              nx_done,
    output logic [IDX_W-1:0]  nx_idx,
    output logic [VPN_W-1:0]  nx_vpn,
    output logic [VPN_W-1:0]  nx_mask,
    output logic [ASID_W-1:0] nx_asid,
    output logic              nx_global,
    output logic              nx_v0,
    output logic              nx_v1,
    output logic [PFN_W-1:0]  nx_pfn0,
    output logic [PFN_W-1:0]  nx_pfn1
);
    import tlb_pkg::*;

    localparam int              PAGE_SHIFT = VA_W - VPN_W;
    localparam logic [VA_W-1:0] UNC_PAT    = VA_W'(UNC_MATCH);

    logic [ENTRIES-1:0][VPN_W-1:0]  t_vpn;
    logic [ENTRIES-1:0][VPN_W-1:0]  t_mask;
    logic [ENTRIES-1:0][ASID_W-1:0] t_asid;
    logic [ENTRIES-1:0]             t_global;
    logic [ENTRIES-1:0]             t_v0;
    logic [ENTRIES-1:0]             t_v1;
    logic [ENTRIES-1:0][PFN_W-1:0]  t_pfn0;
    logic [ENTRIES-1:0][PFN_W-1:0]  t_pfn1;
    logic [IDX_W-1:0]               ptr;
    logic                           ptr_step;
    logic                           nx_go;

    logic [VPN_W-1:0]   q_vpn;
    logic [ENTRIES-1:0] slot_hit;
    logic               any_hit;
    logic [IDX_W-1:0]   win_idx;
    req_kind_e          kind;
    logic               accept;
    logic               misalign;
    logic               eff_hit;
    logic               give_frame;
    logic               unc;

    // Storage, write path, flush and replacement pointer.
    tlb_table #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .ASID_W  (ASID_W),
        .IDX_W   (IDX_W),
        .WIDX_W  (WIDX_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_vpn    (wr_vpn),
        .wr_mask   (wr_mask),
        .wr_asid   (wr_asid),
        .wr_global (wr_global),
        .wr_v0     (wr_v0),
        .wr_v1     (wr_v1),
        .wr_pfn0   (wr_pfn0),
        .wr_pfn1   (wr_pfn1),
        .wr_warn   (wr_warn),
        .ptr_step  (ptr_step),
        .ptr       (ptr),
        .t_vpn     (t_vpn),
        .t_mask    (t_mask),
        .t_asid    (t_asid),
        .t_global  (t_global),
        .t_v0      (t_v0),
        .t_v1      (t_v1),
        .t_pfn0    (t_pfn0),
        .t_pfn1    (t_pfn1)
    );

    // Request page number taken from the upper address bits.
    assign q_vpn = req_va[VA_W-1:PAGE_SHIFT];

    // One comparator per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        tlb_slot_cmp #(
            .VPN_W  (VPN_W),
            .ASID_W (ASID_W)
        ) u_cmp (
            .s_vpn    (t_vpn[g]),
            .s_mask   (t_mask[g]),
            .s_asid   (t_asid[g]),
            .s_global (t_global[g]),
            .s_v0     (t_v0[g]),
            .s_v1     (t_v1[g]),
            .q_vpn    (q_vpn),
            .q_asid   (req_asid),
            .hit      (slot_hit[g])
        );
    end

    // Lowest matching slot wins.
    tlb_first_hit #(
        .N     (ENTRIES),
        .IDX_W (IDX_W)
    ) u_first (
        .hits (slot_hit),
        .any  (any_hit),
        .idx  (win_idx)
    );

    // Request qualification and side checks.
    assign kind       = req_kind_e'(req_kind);
    assign accept     = req_valid && !wr_en && !flush;
    assign misalign   = (kind == KIND_LOOKUP) && req_fetch && (req_va[1:0] != 2'b00);
    assign eff_hit    = any_hit && !misalign;
    assign give_frame = eff_hit && (kind == KIND_LOOKUP);
    assign unc        = (req_va & UNC_PAT) == UNC_PAT;

    // Registered translation result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid       <= 1'b0;
            res_hit         <= 1'b0;
            res_idx         <= '1;
            res_v0          <= 1'b0;
            res_v1          <= 1'b0;
            res_pfn0        <= '0;
            res_pfn1        <= '0;
            res_align_fault <= 1'b0;
            res_uncached    <= 1'b0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_hit         <= eff_hit;
                res_idx         <= eff_hit ? {1'b0, win_idx} : '1;
                res_v0          <= give_frame ? t_v0[win_idx]   : 1'b0;
                res_v1          <= give_frame ? t_v1[win_idx]   : 1'b0;
                res_pfn0        <= give_frame ? t_pfn0[win_idx] : '0;
                res_pfn1        <= give_frame ? t_pfn1[win_idx] : '0;
                res_align_fault <= misalign;
                res_uncached    <= unc;
            end
        end
    end

    // Pointer read is cancelled by a flush; the step follows a taken read.
    assign nx_go    = nx_rd && !flush;
    assign ptr_step = nx_go && nx_adv;

    // Registered copy of the slot at the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nx_done   <= 1'b0;
            nx_idx    <= '0;
            nx_vpn    <= '0;
            nx_mask   <= '0;
            nx_asid   <= '0;
            nx_global <= 1'b0;
            nx_v0     <= 1'b0;
            nx_v1     <= 1'b0;
            nx_pfn0   <= '0;
            nx_pfn1   <= '0;
        end else begin
            nx_done <= nx_go;
            if (nx_go) begin
                nx_idx    <= ptr;
                nx_vpn    <= t_vpn[ptr];
                nx_mask   <= t_mask[ptr];
                nx_asid   <= t_asid[ptr];
                nx_global <= t_global[ptr];
                nx_v0     <= t_v0[ptr];
                nx_v1     <= t_v1[ptr];
                nx_pfn0   <= t_pfn0[ptr];
                nx_pfn1   <= t_pfn1[ptr];
            end
        end
    end
endmodule

// File: rtl/tlb_assoc_chk.sv
// Module: tlb_assoc_chk
// Port-level temporal checks for tlb_assoc, attached by bind below.
// Assumes: synchronous active-low reset; all checks idle while in reset.
module tlb_assoc_chk #(
    parameter int          ENTRIES   = 8,
    parameter int          VA_W      = 32,
    parameter logic [31:0] UNC_MATCH = 32'hA000_0000,
    parameter int          IDX_W     = $clog2(ENTRIES),
    parameter int          WIDX_W    = IDX_W + 1,
    parameter int          RES_W     = IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_kind,
    input logic              req_fetch,
    input logic [VA_W-1:0]   req_va,
    input logic              res_valid,
    input logic              res_hit,
    input logic [RES_W-1:0]  res_idx,
    input logic              res_align_fault,
    input logic              res_uncached,
    input logic              wr_en,
    input logic [WIDX_W-1:0] wr_idx,
    input logic              wr_warn,
    input logic              flush,
    input logic              nx_rd,
    input logic              nx_adv,
    input logic              nx_done,
    input logic [IDX_W-1:0]  nx_idx
);
    localparam logic [VA_W-1:0]   UNC_PAT = VA_W'(UNC_MATCH);
    localparam logic [WIDX_W-1:0] LIMIT   = WIDX_W'(ENTRIES);
    localparam logic [IDX_W-1:0]  LAST    = IDX_W'(ENTRIES - 1);
    localparam logic [RES_W-1:0]  RLIMIT  = RES_W'(ENTRIES);

    AST_RES_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wr_en && !flush) |=> res_valid); // R5
    AST_RES_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (wr_en || flush)) |=> !res_valid); // R13
    AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_idx == '1)); // R5
    AST_HIT_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (res_idx < RLIMIT)); // R4
    AST_FAULT_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_align_fault) |-> !res_hit); // R11
    AST_FAULT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wr_en && !flush && !req_kind && req_fetch && (req_va[1:0] != 2'b00))
        |=> res_align_fault); // R11
    AST_PROBE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wr_en && !flush && req_kind) |=> !res_align_fault); // R11
    AST_UNCACHED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wr_en && !flush && ((req_va & UNC_PAT) == UNC_PAT)) |=> res_uncached); // R12
    AST_WARN_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx >= LIMIT)) |=> wr_warn); // R8
    AST_WARN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_idx >= LIMIT)) |=> !wr_warn); // R8
    AST_FLUSH_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 (nx_rd && !flush) |=> (nx_idx == '0)); // R9
    AST_PTR_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_rd && !flush) |=> nx_done); // R10
    AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_rd && nx_adv && !flush) ##1 (nx_rd && !flush)
        |=> (nx_idx == (($past(nx_idx) == LAST) ? '0 : $past(nx_idx) + 1'b1))); // R10
endmodule

bind tlb_assoc tlb_assoc_chk #(
    .ENTRIES   (ENTRIES),
    .VA_W      (VA_W),
    .UNC_MATCH (UNC_MATCH),
    .IDX_W     (IDX_W),
    .WIDX_W    (WIDX_W),
    .RES_W     (RES_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_kind        (req_kind),
    .req_fetch       (req_fetch),
    .req_va          (req_va),
    .res_valid       (res_valid),
    .res_hit         (res_hit),
    .res_idx         (res_idx),
    .res_align_fault (res_align_fault),
    .res_uncached    (res_uncached),
    .wr_en           (wr_en),
    .wr_idx          (wr_idx),
    .wr_warn         (wr_warn),
    .flush           (flush),
    .nx_rd           (nx_rd),
    .nx_adv          (nx_adv),
    .nx_done         (nx_done),
    .nx_idx          (nx_idx)
);

// File: tb/tlb_assoc_bench.sv
`timescale 1ns/1ps
// Bench for tlb_assoc: a vector table of translation requests against a
// preloaded table, then directed steps for reset, eviction, range, flush,
// collisions and the replacement pointer.
module tlb_assoc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_kind = 1'b0, req_fetch = 1'b0;
    logic [31:0] req_va = '0;
    logic [7:0]  req_asid = '0;
    logic        res_valid, res_hit, res_v0, res_v1, res_align_fault, res_uncached;
    logic [3:0]  res_idx;
    logic [19:0] res_pfn0, res_pfn1;
    logic        wr_en = 1'b0, wr_global = 1'b0, wr_v0 = 1'b0, wr_v1 = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0, wr_mask = '0, wr_pfn0 = '0, wr_pfn1 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_warn;
    logic        flush = 1'b0, nx_rd = 1'b0, nx_adv = 1'b0;
    logic        nx_done, nx_global, nx_v0, nx_v1;
    logic [2:0]  nx_idx;
    logic [19:0] nx_vpn, nx_mask, nx_pfn0, nx_pfn1;
    logic [7:0]  nx_asid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tlb_assoc u_tlb_assoc (.*);

    // kind, fetch, va, asid, exp hit, exp idx, exp pfn0, exp fault, exp uncached
    typedef struct packed {
        logic        kind;
        logic        fetch;
        logic [31:0] va;
        logic [7:0]  asid;
        logic        hit;
        logic [3:0]  idx;
        logic [19:0] pfn0;
        logic        fault;
        logic        unc;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'h0001_0000, 8'd5, 1'b1, 4'h0, 20'h11111, 1'b0, 1'b0}, // R1 exact page
        '{1'b0, 1'b0, 32'h0001_0000, 8'd6, 1'b0, 4'hF, 20'h00000, 1'b0, 1'b0}, // R2 tag mismatch
        '{1'b0, 1'b0, 32'h0020_7ABC, 8'd5, 1'b1, 4'h1, 20'h33333, 1'b0, 1'b0}, // R1 masked bits
        '{1'b0, 1'b0, 32'h0021_7000, 8'd5, 1'b0, 4'hF, 20'h00000, 1'b0, 1'b0}, // R1 unmasked bit differs
        '{1'b0, 1'b0, 32'h0030_0000, 8'd1, 1'b1, 4'h2, 20'h55555, 1'b0, 1'b0}, // R2 global, R3 odd valid only
        '{1'b0, 1'b0, 32'h0020_0000, 8'd5, 1'b1, 4'h1, 20'h33333, 1'b0, 1'b0}, // R4 overlap, lowest wins
        '{1'b0, 1'b0, 32'h0040_0000, 8'd7, 1'b0, 4'hF, 20'h00000, 1'b0, 1'b0}, // R3 both valid clear
        '{1'b1, 1'b0, 32'h0030_0004, 8'd3, 1'b1, 4'h2, 20'h00000, 1'b0, 1'b0}, // R6 probe hit
        '{1'b1, 1'b0, 32'h0099_9000, 8'd5, 1'b0, 4'hF, 20'h00000, 1'b0, 1'b0}, // R6 probe miss
        '{1'b0, 1'b1, 32'h0001_0002, 8'd5, 1'b0, 4'hF, 20'h00000, 1'b1, 1'b0}, // R11 misaligned fetch
        '{1'b0, 1'b1, 32'h0001_0004, 8'd5, 1'b1, 4'h0, 20'h11111, 1'b0, 1'b0}, // R11 aligned fetch
        '{1'b1, 1'b1, 32'h0001_0001, 8'd5, 1'b1, 4'h0, 20'h00000, 1'b0, 1'b0}, // R11 probe ignores fault
        '{1'b0, 1'b0, 32'hA000_0000, 8'd0, 1'b0, 4'hF, 20'h00000, 1'b0, 1'b1}, // R12 exact pattern
        '{1'b0, 1'b0, 32'hB001_0000, 8'd5, 1'b0, 4'hF, 20'h00000, 1'b0, 1'b1}, // R12 pattern plus bits
        '{1'b0, 1'b0, 32'h8000_0000, 8'd5, 1'b0, 4'hF, 20'h00000, 1'b0, 1'b0}  // R12 one bit missing
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_slot(input logic [3:0] idx, input logic [19:0] vpn, input logic [19:0] mask,
                              input logic [7:0] asid, input logic g, input logic v0, input logic v1,
                              input logic [19:0] p0, input logic [19:0] p1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_mask = mask; wr_asid = asid;
        wr_global = g; wr_v0 = v0; wr_v1 = v1; wr_pfn0 = p0; wr_pfn1 = p1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic request(input logic kind, input logic fetch, input logic [31:0] va, input logic [7:0] asid);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_fetch = fetch; req_va = va; req_asid = asid;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ptr_read(input logic adv);
        @(negedge clk);
        nx_rd = 1'b1; nx_adv = adv;
        @(negedge clk);
        nx_rd = 1'b0; nx_adv = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #500000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        check("R5 reset outputs", {60'd0, res_valid, wr_warn, nx_done, res_hit}, 64'd0);
        ptr_read(1'b0);
        check("R10 pointer after reset", {nx_done, nx_idx, nx_vpn}, {1'b1, 3'd0, 20'h0});

        // Load table.
        write_slot(4'd0, 20'h00010, 20'h00000, 8'd5, 1'b0, 1'b1, 1'b0, 20'h11111, 20'h22222);
        check("R8 in-range write no warn", {63'd0, wr_warn}, 64'd0);
        write_slot(4'd1, 20'h00200, 20'h0000F, 8'd5, 1'b0, 1'b1, 1'b1, 20'h33333, 20'h44444);
        write_slot(4'd2, 20'h00300, 20'h00000, 8'd9, 1'b1, 1'b0, 1'b1, 20'h55555, 20'h66666);
        write_slot(4'd3, 20'h00200, 20'h00000, 8'd5, 1'b0, 1'b1, 1'b0, 20'h0AAAA, 20'h0BBBB);
        write_slot(4'd4, 20'h00400, 20'h00000, 8'd7, 1'b0, 1'b0, 1'b0, 20'h0CCCC, 20'h0DDDD);

        // Vector walk.
        for (int i = 0; i < NV; i++) begin
            request(VECS[i].kind, VECS[i].fetch, VECS[i].va, VECS[i].asid);
            check($sformatf("vector %0d (R1..R12 as tagged)", i),
                  {res_valid, res_hit, res_idx, res_pfn0, res_align_fault, res_uncached},
                  {1'b1, VECS[i].hit, VECS[i].idx, VECS[i].pfn0, VECS[i].fault, VECS[i].unc});
        end

        // R5 both halves of a lookup hit.
        request(1'b0, 1'b0, 32'h0020_0000, 8'd5);
        check("R5 lookup frames", {res_v0, res_v1, res_pfn0, res_pfn1}, {1'b1, 1'b1, 20'h33333, 20'h44444});
        // R6 probe hides frames.
        request(1'b1, 1'b0, 32'h0020_0000, 8'd5);
        check("R6 probe frames zero", {res_hit, res_idx, res_v0, res_v1, res_pfn1}, {1'b1, 4'h1, 1'b0, 1'b0, 20'h0});

        // R8 out-of-range writes.
        write_slot(4'd8, 20'h00777, 20'h00000, 8'd5, 1'b1, 1'b1, 1'b1, 20'h12345, 20'h12345);
        check("R8 warn at index 8", {63'd0, wr_warn}, 64'd1);
        @(negedge clk);
        check("R8 warn one cycle", {63'd0, wr_warn}, 64'd0);
        write_slot(4'd15, 20'h00777, 20'h00000, 8'd5, 1'b1, 1'b1, 1'b1, 20'h12345, 20'h12345);
        check("R8 warn at index 15", {63'd0, wr_warn}, 64'd1);
        request(1'b0, 1'b0, 32'h0077_7000, 8'd5);
        check("R8 table unchanged", {res_valid, res_hit, res_idx}, {1'b1, 1'b0, 4'hF});

        // R7 overwrite evicts slot 1.
        write_slot(4'd1, 20'h00500, 20'h00000, 8'd5, 1'b0, 1'b1, 1'b0, 20'h77777, 20'h0);
        request(1'b0, 1'b0, 32'h0020_7000, 8'd5);
        check("R7 old masked mapping gone", {res_hit, res_idx}, {1'b0, 4'hF});
        request(1'b0, 1'b0, 32'h0020_0000, 8'd5);
        check("R7 next overlap wins", {res_hit, res_idx, res_pfn0}, {1'b1, 4'h3, 20'h0AAAA});
        request(1'b0, 1'b0, 32'h0050_0000, 8'd5);
        check("R7 new mapping", {res_hit, res_idx, res_pfn0}, {1'b1, 4'h1, 20'h77777});

        // R13 write collides with a request.
        @(negedge clk);
        req_valid = 1'b1; req_kind = 1'b0; req_va = 32'h0001_0000; req_asid = 8'd5; req_fetch = 1'b0;
        wr_en = 1'b1; wr_idx = 4'd6; wr_vpn = 20'h00600; wr_mask = '0; wr_asid = 8'd5;
        wr_global = 1'b0; wr_v0 = 1'b1; wr_v1 = 1'b0; wr_pfn0 = 20'h06060; wr_pfn1 = '0;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        check("R13 request dropped on write", {63'd0, res_valid}, 64'd0);

        // R10 pointer walk and wrap.
        for (int i = 0; i < 8; i++) begin
            ptr_read(1'b1);
            check($sformatf("R10 pointer step %0d", i), {nx_done, nx_idx}, {1'b1, 3'(i)});
        end
        ptr_read(1'b0);
        check("R10 pointer wrapped", {nx_idx, nx_vpn, nx_asid, nx_v0}, {3'd0, 20'h00010, 8'd5, 1'b1});
        ptr_read(1'b1);
        check("R10 no-advance holds", {60'd0, 1'b0, nx_idx}, 64'd0);
        ptr_read(1'b0);
        check("R10 pointer contents slot 1", {nx_idx, nx_vpn, nx_pfn0}, {3'd1, 20'h00500, 20'h77777});

        // R9 flush.
        ptr_read(1'b1);
        @(negedge clk);
        flush = 1'b1;
        req_valid = 1'b1; req_va = 32'h0001_0000; req_asid = 8'd5;
        @(negedge clk);
        flush = 1'b0; req_valid = 1'b0;
        check("R13 request dropped on flush", {63'd0, res_valid}, 64'd0);
        request(1'b0, 1'b0, 32'h0030_0000, 8'd9);
        check("R9 global slot flushed", {res_hit, res_idx}, {1'b0, 4'hF});
        ptr_read(1'b0);
        check("R9 pointer and slot cleared", {nx_idx, nx_vpn, nx_v0, nx_v1, nx_pfn0},
              {3'd0, 20'h0, 1'b0, 1'b0, 20'h0});

        // R13 flush beats a write and a pointer read in the same cycle.
        @(negedge clk);
        flush = 1'b1; nx_rd = 1'b1; nx_adv = 1'b1;
        wr_en = 1'b1; wr_idx = 4'd0; wr_vpn = 20'h00010; wr_mask = '0; wr_asid = 8'd5;
        wr_global = 1'b1; wr_v0 = 1'b1; wr_v1 = 1'b1; wr_pfn0 = 20'h1; wr_pfn1 = 20'h2;
        @(negedge clk);
        flush = 1'b0; wr_en = 1'b0; nx_rd = 1'b0; nx_adv = 1'b0;
        check("R13 pointer read cancelled", {63'd0, nx_done}, 64'd0);
        request(1'b0, 1'b0, 32'h0001_0000, 8'd5);
        check("R13 flush beats write", {res_hit, res_idx}, {1'b0, 4'hF});

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule